// File: doc/BRIEF.md
# Ring Node Clock Offset Calculator

This block works out how far one node's free-running timestamp counter is from the master's counter in a one-way ring of nodes. Each node stamps the arrival of a synchronization frame and the moment it sends that frame on. From these two stamps the node derives its own forwarding delay. Later messages give the node three things: the master's send time, the forwarding delays that upstream nodes report, and the average per-link cable delay. From these the node predicts when the frame should have reached it. It then reports the difference from its own receive stamp as a signed counter error, in counter ticks. At 100 MHz one tick is 10 ns.

The same block also does the master's part. The master takes its own send and return stamps to get the total ring time. It subtracts the sum of all slave forwarding delays from that time and divides the result by the slave count. A small multi-cycle divider does the division. The result is kept and used again in every later round until a new calculation or a new link-delay message replaces it. Framing, serialization and counter slewing are handled elsewhere.

All timestamp arithmetic wraps modulo 2^TS_W, so a counter rollover between two stamps does no harm.

Top module: `ring_offset_calc`

## Requirements
- R1: One cycle after `tx_stb`, `own_pt` holds `local_time` at the `tx_stb` cycle minus `local_time` at the last `rx_stb`, and `own_pt_valid` pulses for exactly that cycle.
- R2: All differences are taken modulo 2^TS_W. A forward stamp that is numerically below the receive stamp because the counter wrapped still gives the true small delay.
- R3: On `avg_go`, the divisor `node_cnt` is latched. Then `avg_out` becomes floor(((rx stamp − tx stamp) − S) mod 2^TS_W / node_cnt), and `avg_done` pulses in the cycle the new value appears. S is the sum of the stored delays from ids 1..`node_cnt`.
- R4: `avg_out` changes only after an `avg_done` or the cycle after an `avg_msg_valid` (which loads `avg_msg_val`). It survives `round_clr` and later rounds unchanged.
- R5: One cycle after `err_go`, `err_valid` pulses and `err_val` = mtx + `node_idx`×avg + U − rx stamp. Here mtx is the last `mtx_time` taken on `mtx_valid`, and U is the sum of stored delays from ids 1..`node_idx`−1. For `node_idx`=1, U is zero.
- R6: A delay message from id 0 (the master), or from an id ≥ `node_idx`, has no effect on `err_val`.
- R7: A second delay message from the same id replaces that id's earlier value in both sums; it is not added on top.
- R8: `round_clr` clears all stored upstream delays, so both sums are zero in the following cycle.
- R9: During and after reset, `own_pt_valid`, `err_valid` and `avg_done` are low, and `avg_out`, `err_val` and `own_pt` are zero.
- R10: `err_val` is two's complement. It is negative when the local receive stamp is later than the predicted arrival time.
- R11: An `avg_go` that arrives while a division is running is ignored. The result in progress keeps its original divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timestamp clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| local_time | input | TS_W | Free-running local counter value |
| rx_stb | input | 1 | Frame received; capture local_time as rx stamp |
| tx_stb | input | 1 | Frame sent on; capture local_time as tx stamp |
| node_idx | input | ID_W | This node's position in the ring (1..n) |
| node_cnt | input | ID_W | Number of slave nodes n |
| round_clr | input | 1 | Start of a round; clear stored upstream delays |
| mtx_valid | input | 1 | Master send time message present |
| mtx_time | input | TS_W | Master send time |
| pt_msg_valid | input | 1 | Forwarding delay message present |
| pt_msg_id | input | ID_W | Sender id of the delay message |
| pt_msg_val | input | TS_W | Reported forwarding delay |
| avg_msg_valid | input | 1 | Average link delay message present |
| avg_msg_val | input | TS_W | Average link delay value |
| err_go | input | 1 | Compute the counter error |
| avg_go | input | 1 | Master: start the average link delay division |
| own_pt | output | TS_W | This node's forwarding delay |
| own_pt_valid | output | 1 | Pulse: own_pt updated |
| err_val | output | TS_W | Signed counter error, in ticks |
| err_valid | output | 1 | Pulse: err_val updated |
| avg_out | output | TS_W | Stored average link delay |
| avg_done | output | 1 | Pulse: avg_out updated by the divider |

## Verification
A table of rounds drives the error path with different node positions, link delays and upstream delay sets. Some rounds have the counter wrapped between the master send time and the local stamp. Every round also sends delays from id 0 and from ids at or beyond the node's own position. Position 1 shows that upstream delays are left out, and deeper positions show that the right subset is summed. Separate tests cover the following:
- A reversed (wrapped) stamp pair for the forwarding delay.
- A master division where an id above the slave count is excluded.
- A second `avg_go` issued while a division is running.
- A repeated delay from the same id.
- A clear that leaves the sums empty.
- Negative results.
- Reuse of the stored average in a later round.

// File: rtl/ring_sync_pkg.sv
package ring_sync_pkg;
  localparam int TS_W_DEF = 32;
  localparam int ID_W_DEF = 3;

  typedef enum logic {
    DIV_IDLE = 1'b0,
    DIV_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/ring_stamp_cap.sv
module ring_stamp_cap #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] local_time,
  input  logic            rx_stb,
  input  logic            tx_stb,
  output logic [TS_W-1:0] rx_ts,
  output logic [TS_W-1:0] tx_ts,
  output logic [TS_W-1:0] own_pt,
  output logic            own_pt_valid
);
  logic [TS_W-1:0] rx_q, rx_n, tx_q, tx_n, pt_q, pt_n;
  logic            pv_q, pv_n;

  always_comb begin
    rx_n = rx_q;
    tx_n = tx_q;
    pt_n = pt_q;
    pv_n = 1'b0;
    if (rx_stb) rx_n = local_time;
    if (tx_stb) begin
      tx_n = local_time;
      pt_n = local_time - rx_q;   // wraps modulo 2^TS_W
      pv_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
      tx_q <= '0;
      pt_q <= '0;
      pv_q <= 1'b0;
    end else begin
      rx_q <= rx_n;
      tx_q <= tx_n;
      pt_q <= pt_n;
      pv_q <= pv_n;
    end
  end

  assign rx_ts        = rx_q;
  assign tx_ts        = tx_q;
  assign own_pt       = pt_q;
  assign own_pt_valid = pv_q;

  assert_pt_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    own_pt_valid |-> $past(tx_stb));
  assert_pt_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_stb) |-> $stable(own_pt));
endmodule

// File: rtl/ring_delay_store.sv
module ring_delay_store #(
  parameter int TS_W = 32,
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            round_clr,
  input  logic [ID_W-1:0] node_idx,
  input  logic [ID_W-1:0] node_cnt,
  input  logic            msg_valid,
  input  logic [ID_W-1:0] msg_id,
  input  logic [TS_W-1:0] msg_val,
  output logic [TS_W-1:0] up_sum,
  output logic [TS_W-1:0] all_sum
);
  localparam int SLOTS = 2 ** ID_W;

  logic [TS_W-1:0] dly_q [SLOTS];
  logic [TS_W-1:0] dly_n [SLOTS];
  logic [TS_W-1:0] up_q, up_n, all_q, all_n;
  logic            is_slave;

  assign is_slave = (msg_id != '0);

  always_comb begin
    for (int k = 0; k < SLOTS; k++) dly_n[k] = dly_q[k];
    up_n  = up_q;
    all_n = all_q;
    if (round_clr) begin
      for (int k = 0; k < SLOTS; k++) dly_n[k] = '0;
      up_n  = '0;
      all_n = '0;
    end else if (msg_valid) begin
      dly_n[msg_id] = msg_val;
      // replace the previous contribution of this sender
      if (is_slave && (msg_id < node_idx))
        up_n = up_q + msg_val - dly_q[msg_id];
      if (is_slave && (msg_id <= node_cnt))
        all_n = all_q + msg_val - dly_q[msg_id];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SLOTS; k++) dly_q[k] <= '0;
      up_q  <= '0;
      all_q <= '0;
    end else begin
      for (int k = 0; k < SLOTS; k++) dly_q[k] <= dly_n[k];
      up_q  <= up_n;
      all_q <= all_n;
    end
  end

  assign up_sum  = up_q;
  assign all_sum = all_q;

  assert_sum_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(round_clr) |-> (up_sum == '0 && all_sum == '0));
  assert_master_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(msg_valid) && $past(msg_id) == '0 && !$past(round_clr)) |-> $stable(up_sum));
endmodule

// File: rtl/ring_div.sv
module ring_div
  import ring_sync_pkg::*;
#(
  parameter int W    = 32,
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [W-1:0]    num,
  input  logic [ID_W-1:0] den,
  output logic [W-1:0]    quo,
  output logic            done
);
  localparam int CNT_W = $clog2(W);

  div_state_e       st_q, st_n;
  logic [W-1:0]     quo_q, quo_n;
  logic [ID_W-1:0]  rem_q, rem_n, den_q, den_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             done_q, done_n, qbit;

  assign qbit = ({rem_q, quo_q[W-1]} >= {1'b0, den_q});

  always_comb begin
    st_n   = st_q;
    quo_n  = quo_q;
    rem_n  = rem_q;
    den_n  = den_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    case (st_q)
      DIV_IDLE: if (go) begin
        st_n  = DIV_RUN;
        quo_n = num;
        den_n = den;
        rem_n = '0;
        cnt_n = '0;
      end
      DIV_RUN: begin
        rem_n = qbit ? ID_W'({rem_q, quo_q[W-1]} - {1'b0, den_q})
                     : ID_W'({rem_q, quo_q[W-1]});
        quo_n = {quo_q[W-2:0], qbit};
        cnt_n = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(W - 1)) begin
          st_n   = DIV_IDLE;
          done_n = 1'b1;
        end
      end
      default: st_n = DIV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DIV_IDLE;
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      quo_q  <= quo_n;
      rem_q  <= rem_n;
      den_q  <= den_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign quo  = quo_q;
  assign done = done_q;

  assert_done_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st_q == DIV_RUN));
  assert_den_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DIV_RUN && $past(st_q == DIV_RUN)) |-> $stable(den_q));
endmodule

// File: rtl/ring_offset_calc.sv
module ring_offset_calc
  import ring_sync_pkg::*;
#(
  parameter int TS_W = TS_W_DEF,
  parameter int ID_W = ID_W_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TS_W-1:0]        local_time,
  input  logic                   rx_stb,
  input  logic                   tx_stb,
  input  logic [ID_W-1:0]        node_idx,
  input  logic [ID_W-1:0]        node_cnt,
  input  logic                   round_clr,
  input  logic                   mtx_valid,
  input  logic [TS_W-1:0]        mtx_time,
  input  logic                   pt_msg_valid,
  input  logic [ID_W-1:0]        pt_msg_id,
  input  logic [TS_W-1:0]        pt_msg_val,
  input  logic                   avg_msg_valid,
  input  logic [TS_W-1:0]        avg_msg_val,
  input  logic                   err_go,
  input  logic                   avg_go,
  output logic [TS_W-1:0]        own_pt,
  output logic                   own_pt_valid,
  output logic signed [TS_W-1:0] err_val,
  output logic                   err_valid,
  output logic [TS_W-1:0]        avg_out,
  output logic                   avg_done
);
  logic [1:0]      rst_sync_q;
  logic            core_rst_n;
  logic [TS_W-1:0] rx_ts, tx_ts, up_sum, all_sum, div_q, ring_num;
  logic            div_done;
  logic [TS_W-1:0] mtx_q, mtx_n, avg_q, avg_n, err_q, err_n;
  logic            ev_q, ev_n, ad_q, ad_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  ring_stamp_cap #(.TS_W(TS_W)) u_cap (
    .clk(clk), .rst_n(core_rst_n), .local_time(local_time),
    .rx_stb(rx_stb), .tx_stb(tx_stb), .rx_ts(rx_ts), .tx_ts(tx_ts),
    .own_pt(own_pt), .own_pt_valid(own_pt_valid));

  ring_delay_store #(.TS_W(TS_W), .ID_W(ID_W)) u_store (
    .clk(clk), .rst_n(core_rst_n), .round_clr(round_clr),
    .node_idx(node_idx), .node_cnt(node_cnt), .msg_valid(pt_msg_valid),
    .msg_id(pt_msg_id), .msg_val(pt_msg_val),
    .up_sum(up_sum), .all_sum(all_sum));

  // ring total minus slave forwarding delays, modulo 2^TS_W
  assign ring_num = rx_ts - tx_ts - all_sum;

  ring_div #(.W(TS_W), .ID_W(ID_W)) u_div (
    .clk(clk), .rst_n(core_rst_n), .go(avg_go), .num(ring_num),
    .den(node_cnt), .quo(div_q), .done(div_done));

  always_comb begin
    mtx_n = mtx_valid ? mtx_time : mtx_q;
    avg_n = avg_q;
    if (div_done)           avg_n = div_q;
    else if (avg_msg_valid) avg_n = avg_msg_val;
    ad_n  = div_done;
    ev_n  = err_go;
    err_n = err_go ? (mtx_q + (TS_W'(node_idx) * avg_q) + up_sum - rx_ts) : err_q;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      mtx_q <= '0;
      avg_q <= '0;
      err_q <= '0;
      ev_q  <= 1'b0;
      ad_q  <= 1'b0;
    end else begin
      mtx_q <= mtx_n;
      avg_q <= avg_n;
      err_q <= err_n;
      ev_q  <= ev_n;
      ad_q  <= ad_n;
    end
  end

  assign err_val   = $signed(err_q);
  assign err_valid = ev_q;
  assign avg_out   = avg_q;
  assign avg_done  = ad_q;

  assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!core_rst_n)
    err_valid |-> $past(err_go));
  assert_avg_hold_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!$past(div_done) && !$past(avg_msg_valid)) |-> $stable(avg_out));
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !core_rst_n |-> (!err_valid && !avg_done && !own_pt_valid));
endmodule

// File: tb/sim_ring_offset_calc.sv
module sim_ring_offset_calc;
  localparam int TS_W = 32;
  localparam int ID_W = 3;
  localparam int NV   = 6;

  typedef struct packed {
    logic [ID_W-1:0] idx;
    logic [TS_W-1:0] mtx;
    logic [TS_W-1:0] avg;
    logic [TS_W-1:0] rx;
    logic [TS_W-1:0] d0;
    logic [TS_W-1:0] d1;
    logic [TS_W-1:0] d2;
    logic [TS_W-1:0] d3;
  } vec_t;

  // rounds: position, master send, link delay, local rx, delays from ids 0..3
  localparam vec_t VECS [NV] = '{
    '{3'd1, 32'd1000,        32'd50, 32'd1040,      32'd999, 32'd7,  32'd9,  32'd11},
    '{3'd2, 32'd1000,        32'd50, 32'd1110,      32'd999, 32'd7,  32'd9,  32'd11},
    '{3'd3, 32'd5000,        32'd25, 32'd5010,      32'd1,   32'd4,  32'd6,  32'd8},
    '{3'd4, 32'd200,         32'd30, 32'd400,       32'd77,  32'd10, 32'd20, 32'd40},
    '{3'd1, 32'hFFFF_FFF0,   32'd40, 32'h0000_0030, 32'd5,   32'd5,  32'd5,  32'd5},
    '{3'd3, 32'hFFFF_FF00,   32'd64, 32'h0000_0020, 32'd0,   32'd16, 32'd32, 32'd48}
  };

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic [TS_W-1:0]        local_time;
  logic                   rx_stb, tx_stb, round_clr, mtx_valid, pt_msg_valid;
  logic                   avg_msg_valid, err_go, avg_go;
  logic [ID_W-1:0]        node_idx, node_cnt, pt_msg_id;
  logic [TS_W-1:0]        mtx_time, pt_msg_val, avg_msg_val;
  logic [TS_W-1:0]        own_pt, avg_out;
  logic signed [TS_W-1:0] err_val;
  logic                   own_pt_valid, err_valid, avg_done;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ring_offset_calc #(.TS_W(TS_W), .ID_W(ID_W)) u0 (
    .clk(clk), .rst_n(rst_n), .local_time(local_time), .rx_stb(rx_stb),
    .tx_stb(tx_stb), .node_idx(node_idx), .node_cnt(node_cnt),
    .round_clr(round_clr), .mtx_valid(mtx_valid), .mtx_time(mtx_time),
    .pt_msg_valid(pt_msg_valid), .pt_msg_id(pt_msg_id), .pt_msg_val(pt_msg_val),
    .avg_msg_valid(avg_msg_valid), .avg_msg_val(avg_msg_val), .err_go(err_go),
    .avg_go(avg_go), .own_pt(own_pt), .own_pt_valid(own_pt_valid),
    .err_val(err_val), .err_valid(err_valid), .avg_out(avg_out),
    .avg_done(avg_done));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [TS_W-1:0] act,
                       input logic [TS_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic stamp_rx(input logic [TS_W-1:0] t);
    local_time = t; rx_stb = 1'b1; tick(); rx_stb = 1'b0;
  endtask

  task automatic stamp_tx(input logic [TS_W-1:0] t);
    local_time = t; tx_stb = 1'b1; tick(); tx_stb = 1'b0;
  endtask

  task automatic send_pt(input logic [ID_W-1:0] id, input logic [TS_W-1:0] v);
    pt_msg_id = id; pt_msg_val = v; pt_msg_valid = 1'b1; tick(); pt_msg_valid = 1'b0;
  endtask

  task automatic clr_round();
    round_clr = 1'b1; tick(); round_clr = 1'b0;
  endtask

  task automatic set_avg(input logic [TS_W-1:0] v);
    avg_msg_val = v; avg_msg_valid = 1'b1; tick(); avg_msg_valid = 1'b0;
  endtask

  task automatic set_mtx(input logic [TS_W-1:0] v);
    mtx_time = v; mtx_valid = 1'b1; tick(); mtx_valid = 1'b0;
  endtask

  task automatic run_err(input string req, input logic [TS_W-1:0] exp);
    err_go = 1'b1; tick(); err_go = 1'b0;
    check({req, " err_valid"}, TS_W'(err_valid), 1);
    check({req, " err_val"}, err_val, exp);
  endtask

  task automatic run_avg(input string req, input logic [TS_W-1:0] exp);
    int waited;
    avg_go = 1'b1; tick(); avg_go = 1'b0;
    waited = 0;
    while (!avg_done && waited < 100) begin tick(); waited++; end
    check({req, " avg_done"}, TS_W'(avg_done), 1);
    check({req, " avg_out"}, avg_out, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [TS_W-1:0] e;
    rst_n = 1'b0; local_time = '0; rx_stb = 0; tx_stb = 0; round_clr = 0;
    mtx_valid = 0; pt_msg_valid = 0; avg_msg_valid = 0; err_go = 0; avg_go = 0;
    node_idx = 3'd1; node_cnt = 3'd1; pt_msg_id = '0; mtx_time = '0;
    pt_msg_val = '0; avg_msg_val = '0;
    repeat (3) tick();
    // R9: quiet outputs in reset
    check("R9 own_pt_valid", TS_W'(own_pt_valid), 0);
    check("R9 err_valid", TS_W'(err_valid), 0);
    check("R9 avg_done", TS_W'(avg_done), 0);
    check("R9 avg_out", avg_out, 0);
    check("R9 err_val", err_val, 0);
    check("R9 own_pt", own_pt, 0);
    rst_n = 1'b1;
    repeat (3) tick();

    // table of rounds: R5 formula, R6 id 0 and ids >= position ignored
    for (int v = 0; v < NV; v++) begin
      clr_round();
      node_idx = VECS[v].idx;
      set_avg(VECS[v].avg);
      set_mtx(VECS[v].mtx);
      stamp_rx(VECS[v].rx);
      send_pt(3'd0, VECS[v].d0);
      send_pt(3'd1, VECS[v].d1);
      send_pt(3'd2, VECS[v].d2);
      send_pt(3'd3, VECS[v].d3);
      e = VECS[v].mtx + TS_W'(VECS[v].idx) * VECS[v].avg - VECS[v].rx;
      if (VECS[v].idx > 1) e = e + VECS[v].d1;
      if (VECS[v].idx > 2) e = e + VECS[v].d2;
      if (VECS[v].idx > 3) e = e + VECS[v].d3;
      run_err("R5 R6 table", e);
    end

    // R1: forwarding delay
    stamp_rx(32'd300);
    stamp_tx(32'd345);
    check("R1 own_pt_valid", TS_W'(own_pt_valid), 1);
    check("R1 own_pt", own_pt, 45);
    tick();
    check("R1 pulse ends", TS_W'(own_pt_valid), 0);
    // R2: wrap between rx and tx stamps
    stamp_rx(32'hFFFF_FFF0);
    stamp_tx(32'h0000_0010);
    check("R2 wrapped own_pt", own_pt, 32);

    // R3: master average, id above slave count excluded
    clr_round();
    node_cnt = 3'd2;
    stamp_tx(32'd100);
    stamp_rx(32'd600);
    send_pt(3'd1, 32'd20);
    send_pt(3'd2, 32'd30);
    send_pt(3'd3, 32'd1000);
    run_avg("R3 master n=2", 32'd225);

    // R11: second start while running is ignored (n=3 kept, not 2)
    clr_round();
    node_cnt = 3'd3;
    stamp_tx(32'd0);
    stamp_rx(32'd600);
    send_pt(3'd1, 32'd30);
    send_pt(3'd2, 32'd60);
    send_pt(3'd3, 32'd90);
    avg_go = 1'b1; tick(); avg_go = 1'b0;
    tick();
    node_cnt = 3'd2;
    avg_go = 1'b1; tick(); avg_go = 1'b0;
    for (int w = 0; w < 100 && !avg_done; w++) tick();
    check("R11 avg_out keeps first divisor", avg_out, 140);
    repeat (40) tick();
    check("R11 no second result", avg_out, 140);

    // R4: stored average reused after a new round
    clr_round();
    node_idx = 3'd2;
    set_mtx(32'd1000);
    stamp_rx(32'd1300);
    check("R4 avg_out held", avg_out, 140);
    run_err("R4 reuse", 32'd1000 + 32'd280 - 32'd1300);

    // R7: repeated id replaces; R10: negative error
    clr_round();
    node_idx = 3'd3;
    set_avg(32'd10);
    set_mtx(32'd0);
    stamp_rx(32'd100);
    send_pt(3'd1, 32'd5);
    send_pt(3'd1, 32'd8);
    send_pt(3'd2, 32'd4);
    run_err("R7 R10 replace", -32'sd58);

    // R8: clear empties the sums
    clr_round();
    run_err("R8 cleared", -32'sd70);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule